// File: doc/BRIEF.md
# Interrupt Mask and Condition Unit

This unit turns the status word of a two-wire bus controller into interrupt conditions and one level interrupt line. Each cycle it takes the upper half of the status vector, which the transfer sequencer drives, and stores it as the raw condition. The raw condition keeps the bit layout of the status word's upper half. Those bits are invalid command, parity fault, back-end overrun, back-end access fault, lost arbitration, missing acknowledge, data request, command done, stop fault, busy, not busy, and the clock and data line level flags. A software-visible mask selects which raw bits may raise the interrupt line.

Software reaches the unit through a small register window with a combinational read path. The mask has three ways to be written. A direct write replaces it. A write to the raw-condition offset sets bits in it. A write to the masked-condition offset keeps only the bits written as one. A write to the clear offset restarts the unit's state in the same way a controller reset does.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset, all three readable offsets return zero and `irqOut` is low.
- R2: A read at offset 1 returns the raw condition. Bit i of the raw condition equals bit (COND_W + i) of `statusIn`, captured at the previous clock edge. The lower half of `statusIn` has no effect.
- R3: A read at offset 2 returns the raw condition ANDed with the mask.
- R4: `irqOut` is high exactly when the masked condition is nonzero. It follows a change on `statusIn` one clock edge later.
- R5: A write at offset 0 replaces the whole mask with `wrData`. A read at offset 0 returns the mask.
- R6: A write at offset 1 ORs `wrData` into the mask.
- R7: A write at offset 2 ANDs `wrData` into the mask.
- R8: A write at offset 3 clears the mask and the raw condition at that edge. The raw condition loads from `statusIn` again at the next edge.
- R9: The mask does not change in cycles with no write, or with a write to an offset from 4 upwards. Reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| statusIn | input | STAT_W | Status vector from the transfer sequencer |
| wrEn | input | 1 | Register write strobe for this cycle |
| addr | input | ADDR_W | Register offset for reads and writes |
| wrData | input | COND_W | Write data |
| rdData | output | COND_W | Read data for `addr`, combinational |
| irqOut | output | 1 | Level interrupt, high while any unmasked condition is set |

## Verification
A wrong mask bit shows up on the first read of offset 0 or offset 2 after the write that set it up. It also flips `irqOut` in that same cycle whenever the matching raw bit is set. A capture that is stale or shifted shows on the offset-1 read one cycle after the status change. The stimulus puts single bits at both ends of the condition field so that this kind of fault is exposed. If the clear write fails to empty the raw condition, the fault is only visible during the single cycle after that write, so the bench samples exactly in that cycle.

// File: rtl/irqmask_pkg.sv
package irqmask_pkg;

  localparam int unsigned OFF_MASK  = 0;
  localparam int unsigned OFF_RAW   = 1;
  localparam int unsigned OFF_COND  = 2;
  localparam int unsigned OFF_CLEAR = 3;

  typedef struct packed {
    logic loadMask;
    logic orMask;
    logic andMask;
    logic clearAll;
  } maskStrobe_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_RAW  = 2'd2,
    SEL_COND = 2'd3
  } rdSel_t;

endpackage

// File: rtl/irqmask_ctrl.sv
module irqmask_ctrl
  import irqmask_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output maskStrobe_t       strobe,
  output rdSel_t            rdSel
);

  logic hitMask, hitRaw, hitCond, hitClear;

  assign hitMask  = (addr == ADDR_W'(OFF_MASK));
  assign hitRaw   = (addr == ADDR_W'(OFF_RAW));
  assign hitCond  = (addr == ADDR_W'(OFF_COND));
  assign hitClear = (addr == ADDR_W'(OFF_CLEAR));

  always_comb begin
    strobe.loadMask = wrEn && hitMask;
    strobe.orMask   = wrEn && hitRaw;
    strobe.andMask  = wrEn && hitCond;
    strobe.clearAll = wrEn && hitClear;
  end

  always_comb begin
    if (hitMask)      rdSel = SEL_MASK;
    else if (hitRaw)  rdSel = SEL_RAW;
    else if (hitCond) rdSel = SEL_COND;
    else              rdSel = SEL_NONE;
  end

endmodule

// File: rtl/irqmask_dp.sv
module irqmask_dp
  import irqmask_pkg::*;
#(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned COND_W = STAT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  maskStrobe_t       strobe,
  input  rdSel_t            rdSel,
  input  logic [COND_W-1:0] wrData,
  input  logic [STAT_W-1:0] statusIn,
  output logic [COND_W-1:0] rdData,
  output logic [COND_W-1:0] maskQ,
  output logic [COND_W-1:0] rawQ,
  output logic              irqOut
);

  localparam int unsigned LO = STAT_W - COND_W;

  logic [COND_W-1:0] maskNext;
  logic [COND_W-1:0] maskedCond;

  // per-bit mask update: clear wins, then replace, then set, then keep-only
  for (genvar b = 0; b < COND_W; b++) begin : g_maskBit
    always_comb begin
      if (strobe.clearAll)      maskNext[b] = 1'b0;
      else if (strobe.loadMask) maskNext[b] = wrData[b];
      else if (strobe.orMask)   maskNext[b] = maskQ[b] | wrData[b];
      else if (strobe.andMask)  maskNext[b] = maskQ[b] & wrData[b];
      else                      maskNext[b] = maskQ[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      rawQ  <= '0;
    end else begin
      maskQ <= maskNext;
      rawQ  <= strobe.clearAll ? '0 : statusIn[STAT_W-1:LO];
    end
  end

  assign maskedCond = rawQ & maskQ;
  assign irqOut     = |maskedCond;

  always_comb begin
    unique case (rdSel)
      SEL_MASK: rdData = maskQ;
      SEL_RAW:  rdData = rawQ;
      SEL_COND: rdData = maskedCond;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irqmask_pkg::*;
#(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned COND_W = STAT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [COND_W-1:0] wrData,
  output logic [COND_W-1:0] rdData,
  output logic              irqOut
);

  maskStrobe_t       strobe;
  rdSel_t            rdSel;
  logic [COND_W-1:0] maskQ;
  logic [COND_W-1:0] rawQ;

  irqmask_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  irqmask_dp #(.STAT_W(STAT_W), .COND_W(COND_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .statusIn (statusIn),
    .rdData   (rdData),
    .maskQ    (maskQ),
    .rawQ     (rawQ),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/irqmask_checker.sv
module irqmask_checker #(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned COND_W = STAT_W / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [COND_W-1:0] wrData,
  input logic [STAT_W-1:0] statusIn,
  input logic [COND_W-1:0] maskQ,
  input logic [COND_W-1:0] rawQ,
  input logic              irqOut
);

  logic clrHit;
  assign clrHit = wrEn && (addr == ADDR_W'(3));

  assert_raw_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clrHit |=> rawQ == $past(statusIn[STAT_W-1:STAT_W-COND_W]));

  assert_irq_needs_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ != '0));

  assert_irq_needs_raw_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rawQ == '0) |-> !irqOut);

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0)) |=> maskQ == $past(wrData));

  assert_mask_or_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(1)) |=> maskQ == ($past(maskQ) | $past(wrData)));

  assert_mask_and_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(2)) |=> maskQ == ($past(maskQ) & $past(wrData)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrHit |=> (maskQ == '0) && (rawQ == '0) && !irqOut);

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || addr > ADDR_W'(3)) |=> $stable(maskQ));

endmodule

bind irq_mask_unit irqmask_checker #(.STAT_W(STAT_W), .ADDR_W(ADDR_W), .COND_W(COND_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .statusIn (statusIn),
  .maskQ    (maskQ),
  .rawQ     (rawQ),
  .irqOut   (irqOut)
);

// File: tb/tb_irq_mask_unit.sv
module tb_irq_mask_unit;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned COND_W = STAT_W / 2;
  localparam int unsigned NVEC = 8;

  // {wr, addr, data, status, expected mask}
  localparam logic [67:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 16'h00FF, 32'h0081_0000, 16'h00FF},
    {1'b1, 3'd1, 16'h0F00, 32'h0000_1234, 16'h0FFF},
    {1'b1, 3'd2, 16'h00F0, 32'h0180_0000, 16'h00F0},
    {1'b1, 3'd5, 16'hFFFF, 32'h0100_0000, 16'h00F0},
    {1'b0, 3'd0, 16'hFFFF, 32'hFFFF_0000, 16'h00F0},
    {1'b1, 3'd0, 16'h8000, 32'h8000_0000, 16'h8000},
    {1'b1, 3'd2, 16'h0000, 32'h8000_0000, 16'h0000},
    {1'b1, 3'd1, 16'hFFFF, 32'h0001_0000, 16'hFFFF}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [STAT_W-1:0] statusIn = '0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [COND_W-1:0] wrData = '0;
  logic [COND_W-1:0] rdData;
  logic              irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_mask_unit #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a, output logic [COND_W-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  // reads offsets 0..2 and irq in the low phase, no write
  task automatic checkAll(input string tag, input logic [COND_W-1:0] m, input logic [COND_W-1:0] r);
    logic [COND_W-1:0] d;
    wrEn = 1'b0;
    readAt(3'd0, d); check({tag, " R5 mask"}, 32'(d), 32'(m));
    readAt(3'd1, d); check({tag, " R2 raw"}, 32'(d), 32'(r));
    readAt(3'd2, d); check({tag, " R3 masked"}, 32'(d), 32'(m & r));
    check({tag, " R4 irq"}, 32'(irqOut), 32'(|(m & r)));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [COND_W-1:0] d;
    statusIn = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    // R1 reset state
    checkAll("R1 reset", 16'h0000, 16'h0000);
    rstN = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wrEn     = VEC[i][67];
      addr     = VEC[i][66:64];
      wrData   = VEC[i][63:48];
      statusIn = VEC[i][47:16];
      @(negedge clk);
      checkAll($sformatf("vec%0d", i), VEC[i][15:0], VEC[i][47:32]);
    end

    // R9: unused offsets read zero
    readAt(3'd6, d); check("R9 unused read", 32'(d), 32'h0);
    readAt(3'd4, d); check("R9 unused read", 32'(d), 32'h0);

    // R4 latency: status change shows on irq only after an edge
    @(negedge clk);
    statusIn = 32'h0000_0000;
    @(negedge clk);
    check("R4 irq low", 32'(irqOut), 32'h0);
    statusIn = 32'h4000_0000;
    #1;
    check("R4 irq before edge", 32'(irqOut), 32'h0);
    @(negedge clk);
    check("R4 irq after edge", 32'(irqOut), 32'h1);

    // R8 clear write with status held nonzero
    statusIn = 32'hA5A5_0000;
    wrEn = 1'b1; addr = 3'd3; wrData = 16'h1234;
    @(negedge clk);
    checkAll("R8 cleared", 16'h0000, 16'h0000);
    @(negedge clk);
    checkAll("R8 reload", 16'h0000, 16'hA5A5);

    // R2: lower status half ignored
    wrEn = 1'b1; addr = 3'd0; wrData = 16'hFFFF;
    statusIn = 32'h0000_FFFF;
    @(negedge clk);
    checkAll("R2 low half", 16'hFFFF, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule